// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that answers like a byte-wide serial EEPROM. It watches SCL and SDA from the system clock domain and synchronises both lines. It detects START and STOP conditions, then shifts bits in and out on the SCL edges. The target pulls SDA low only through an open-drain drive enable. A register array holds the data. A word address of up to 14 bits, carried in two address bytes, selects a location. `MEM_AW` sets how many of those bits index real storage: 14 gives the full 16,384-byte part, and the default of 11 keeps elaboration small. Address bits above `MEM_AW` alias.

The target supports byte write, page write with partial pages, current-address read, random read and sequential read. Two select pins place up to four of these targets on one bus. A write-protect pin stops the array from changing. When a write transfer closes, a self-timed write period starts. It lasts `WRITE_CYCLES` clocks, and during it the target does not acknowledge its own address, so a host can poll until the write completes. The block has no streamed data port. Its only data path is the I2C bus itself, so there is no valid/ready interface and no back-pressure rule; all pins are plain control levels.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges an address byte only when its top seven bits are 1010, 0, A1, A0 with A1/A0 equal to `dev_sel_i[1:0]`, and it is not busy. Bit 0 of that byte selects read when 1. Any other address gets no acknowledge, and the bus is ignored until the next START.
- R2: In a write transfer, the two bytes that follow the address are the word address, high byte first. The target acknowledges both. The upper two bits of the high byte are ignored.
- R3: Each data byte of a write is acknowledged and stored at the current word address. The low 6 address bits then advance and wrap inside the 64-byte page, and the upper bits stay unchanged.
- R4: A STOP or repeated START that ends a write with at least one stored byte starts a busy period of `WRITE_CYCLES` clocks. During that period the target does not acknowledge its address. A write that ends before any data byte starts no busy period.
- R5: While `wp_i` is high, data bytes are still acknowledged, but nothing is stored and no busy period starts.
- R6: A read with no preceding address bytes returns the byte at the address after the last byte accessed.
- R7: A write of the two address bytes, a repeated START and a read together return the byte at that address.
- R8: During a read, a host acknowledge makes the target send the next byte. The full address increments, and after the last stored byte the next byte comes from byte 0. A host NACK ends the read and the target releases SDA.
- R9: A START at any point, even inside a byte, restarts address reception. A STOP at any point returns the target to idle with SDA released.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released, the word address is 0 and the target is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low (open drain) |
| dev_sel_i | input | 2 | Address select pins A1, A0 |
| wp_i | input | 1 | Write protect, high blocks array writes |

## Verification
The bench builds the target with `MEM_AW` = 8 and `WRITE_CYCLES` = 300. With a 256-byte array, a sequential read that starts at the last byte wraps to byte 0 within two bytes, and page wrap can be seen from page 0. The short write period lets the bench see both sides of acknowledge polling: a poll right after STOP gets no acknowledge, and a poll after the period gets one. The select pins are tied to 10, so addresses with the wrong select bits and the wrong device type both show up as missing acknowledges.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK
  } eep_st_e;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_lvl;
      sda_q    <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] ONE  = 1;

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start_i)        remain <= LOAD;
    else if (remain != '0)   remain <= remain - ONE;
  end

  assign busy_o = (remain != '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int MEM_AW       = 11,
  parameter int WRITE_CYCLES = 500000,
  parameter int PAGE_AW      = 6,
  parameter int WORD_AW      = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] dev_sel_i,
  input  logic       wp_i
);
  localparam int HI_BITS = WORD_AW - 8;
  localparam logic [WORD_AW-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_AW-1:0] PAGE_ONE = 1;
  localparam logic [3:0]         FULL     = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  eep_st_e state, after_ack;
  logic [7:0] sr, tx;
  logic [3:0] bit_cnt;
  logic [WORD_AW-1:0] word_addr, page_next;
  logic master_ack, wrote, busy, tmr_start;
  logic mem_we;
  logic [MEM_AW-1:0] mem_wa;
  logic [7:0] mem_wd, rd_data;
  logic dev_hit;

  eep_bus_sense #(.SYNC_STAGES(2)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .busy_o(busy)
  );

  eep_store #(.AW(MEM_AW), .DW(8)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(word_addr[MEM_AW-1:0]), .rdata(rd_data)
  );

  assign dev_hit = (sr[7:4] == DEV_TYPE) && !sr[3] &&
                   (sr[2:1] == dev_sel_i) && !busy;
  assign page_next = {word_addr[WORD_AW-1:PAGE_AW],
                      word_addr[PAGE_AW-1:0] + PAGE_ONE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      after_ack  <= ST_IDLE;
      sr         <= '0;
      tx         <= '0;
      bit_cnt    <= '0;
      word_addr  <= '0;
      master_ack <= 1'b0;
      wrote      <= 1'b0;
      tmr_start  <= 1'b0;
      sda_pull_o <= 1'b0;
      mem_we     <= 1'b0;
      mem_wa     <= '0;
      mem_wd     <= '0;
    end else begin
      mem_we    <= 1'b0;
      tmr_start <= 1'b0;
      if (start_evt || stop_evt) begin
        // a closed write transfer launches the self-timed period
        if (wrote) begin
          tmr_start <= 1'b1;
          wrote     <= 1'b0;
        end
        state      <= start_evt ? ST_DEV : ST_IDLE;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise) begin
              sr      <= {sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == FULL) begin
              bit_cnt    <= '0;
              sda_pull_o <= 1'b1;
              state      <= ST_ACK;
              if (state == ST_DEV) begin
                if (!dev_hit) begin
                  sda_pull_o <= 1'b0;
                  state      <= ST_IDLE;
                end
                after_ack <= sr[0] ? ST_RDAT : ST_AHI;
              end else if (state == ST_AHI) begin
                word_addr[WORD_AW-1:8] <= sr[HI_BITS-1:0];
                after_ack <= ST_ALO;
              end else if (state == ST_ALO) begin
                word_addr[7:0] <= sr;
                after_ack <= ST_WDAT;
              end else begin
                after_ack <= ST_WDAT;
                if (!wp_i) begin
                  mem_we    <= 1'b1;
                  mem_wa    <= word_addr[MEM_AW-1:0];
                  mem_wd    <= sr;
                  wrote     <= 1'b1;
                  word_addr <= page_next;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state <= after_ack;
              if (after_ack == ST_RDAT) begin
                tx         <= rd_data;
                sda_pull_o <= ~rd_data[7];
                bit_cnt    <= 4'd1;
                word_addr  <= word_addr + ADDR_ONE;
              end else begin
                sda_pull_o <= 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bit_cnt == FULL) begin
                sda_pull_o <= 1'b0;
                state      <= ST_RACK;
              end else begin
                tx         <= {tx[6:0], 1'b0};
                sda_pull_o <= ~tx[6];
                bit_cnt    <= bit_cnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack) begin
                tx         <= rd_data;
                sda_pull_o <= ~rd_data[7];
                bit_cnt    <= 4'd1;
                word_addr  <= word_addr + ADDR_ONE;
                state      <= ST_RDAT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_evt,
  input logic sda_pull_o,
  input logic mem_we,
  input logic wp_i,
  input logic busy,
  input logic tmr_start
);
  // R4
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);

  // R4
  timer_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |=> busy);

  // R5
  protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(!wp_i));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);
endmodule

bind i2c_eeprom_target eep_chk u_eep_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
  .sda_pull_o(sda_pull_o), .mem_we(mem_we), .wp_i(wp_i),
  .busy(busy), .tmr_start(tmr_start)
);

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  localparam int WCYC = 300;
  localparam logic [1:0] SEL = 2'b10;
  localparam logic [7:0] DEV_W = {4'b1010, 1'b0, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, 1'b0, SEL, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_bus;
  int checks = 0;
  int failures = 0;
  int r10_glitch = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_pull);

  i2c_eeprom_target #(.MEM_AW(8), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .dev_sel_i(SEL), .wp_i(wp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    m_low = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    m_low = 1'b0; tick(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; tick(4);
      scl_m = 1'b1; tick(8);
      scl_m = 1'b0; tick(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; tick(4);
    scl_m = 1'b1; tick(4);
    ack = ~sda_bus; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(4);
      scl_m = 1'b1; tick(2);
      d[i] = sda_bus; tick(4);
      if (sda_bus != d[i]) r10_glitch++;
      tick(2);
      scl_m = 1'b0; tick(4);
    end
    m_low = mack; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
    m_low = 1'b0;
  endtask

  // write n bytes (1..4) from addr; returns AND of all acks
  task automatic wr_page(input logic [13:0] a, input int n, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3, output bit all_ack);
    bit ack;
    logic [7:0] bytes [4];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    bus_start();
    send_byte(DEV_W, ack); all_ack = ack;
    send_byte({2'b11, a[13:8]}, ack); all_ack &= ack;
    send_byte(a[7:0], ack); all_ack &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(bytes[i], ack); all_ack &= ack;
    end
    bus_stop();
  endtask

  task automatic poll(output bit ack);
    bus_start();
    send_byte(DEV_W, ack);
    bus_stop();
  endtask

  // random read of n bytes from addr and compare
  task automatic rd_check(input logic [13:0] a, input int n, input logic [7:0] e0,
                          input logic [7:0] e1, input logic [7:0] e2, input string req);
    bit ack;
    logic [7:0] d;
    logic [7:0] exp [3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte({2'b00, a[13:8]}, ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(DEV_R, ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(d === exp[i], req, int'(d), int'(exp[i]));
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_pull === 1'b0, "R11 sda released", int'(sda_pull), 0);
  endtask

  task automatic t_select();
    bit ack;
    bus_start(); send_byte({4'b1010, 1'b0, 2'b01, 1'b0}, ack); bus_stop();
    check(!ack, "R1 wrong select bits nacked", ack, 0);
    bus_start(); send_byte({4'b1011, 1'b0, SEL, 1'b0}, ack); bus_stop();
    check(!ack, "R1 wrong device type nacked", ack, 0);
    poll(ack);
    check(ack, "R1/R11 matching address acked, not busy", ack, 1);
  endtask

  task automatic t_byte_write();
    bit ack;
    wr_page(14'h0005, 1, 8'hA5, 0, 0, 0, ack);
    check(ack, "R2/R3 address and data bytes acked", ack, 1);
    poll(ack);
    check(!ack, "R4 address nacked during write cycle", ack, 0);
    tick(WCYC + 50);
    poll(ack);
    check(ack, "R4 address acked after write cycle", ack, 1);
    rd_check(14'h0005, 1, 8'hA5, 0, 0, "R7 random read of written byte");
  endtask

  task automatic t_page_wrap();
    bit ack;
    wr_page(14'h0040, 1, 8'h77, 0, 0, 0, ack);
    tick(WCYC + 50);
    wr_page(14'h003E, 4, 8'h11, 8'h22, 8'h33, 8'h44, ack);
    check(ack, "R3 page bytes acked", ack, 1);
    tick(WCYC + 50);
    rd_check(14'h003E, 3, 8'h11, 8'h22, 8'h77, "R3 page tail and next page untouched");
    rd_check(14'h0000, 2, 8'h33, 8'h44, 0, "R3 wrapped bytes at page start");
  endtask

  task automatic t_protect();
    bit ack;
    wp = 1'b1;
    wr_page(14'h0005, 1, 8'h5A, 0, 0, 0, ack);
    check(ack, "R5 protected data still acked", ack, 1);
    poll(ack);
    check(ack, "R5 no write cycle while protected", ack, 1);
    wp = 1'b0;
    rd_check(14'h0005, 1, 8'hA5, 0, 0, "R5 protected byte unchanged");
  endtask

  task automatic t_rollover();
    bit ack;
    logic [7:0] d;
    wr_page(14'h00FF, 1, 8'hC3, 0, 0, 0, ack);
    tick(WCYC + 50);
    rd_check(14'h00FF, 2, 8'hC3, 8'h33, 0, "R8 sequential read rolls over to byte 0");
    check(sda_pull === 1'b0, "R8 sda released after nack", int'(sda_pull), 0);
    // address now points at 0x01
    bus_start(); send_byte(DEV_R, ack); recv_byte(1'b0, d); bus_stop();
    check(d === 8'h44, "R6 current address read", int'(d), 'h44);
  endtask

  task automatic t_restart();
    bit ack;
    logic [7:0] d;
    bus_start(); send_byte(DEV_W, ack); send_byte(8'h00, ack); bus_stop();
    poll(ack);
    check(ack, "R9/R4 stop before data starts no write cycle", ack, 1);
    bus_start(); send_bits(8'hFF, 3);
    bus_start(); send_byte(DEV_W, ack);
    check(ack, "R9 start inside a byte restarts address", ack, 1);
    send_byte(8'h00, ack); send_byte(8'h3F, ack);
    bus_start(); send_byte(DEV_R, ack); recv_byte(1'b0, d); bus_stop();
    check(d === 8'h22, "R9 read after restart", int'(d), 'h22);
    check(r10_glitch == 0, "R10 sda steady while scl high", r10_glitch, 0);
  endtask

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_select();
    t_byte_write();
    t_page_wrap();
    t_protect();
    t_rollover();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule